// File: doc/BRIEF.md
# Self-Testing ALU with Branch Remapping

This block is a small arithmetic/logic datapath whose operation is chosen by a one-hot control code held in a register. It has its own self-test logic. In normal operation it registers two operands and a control code from its inputs every cycle. A decoder then sends the operands to one of four functional units: add, subtract, AND and XOR. A control code that is not one-hot selects no unit, and the result is zero.

When `test_mode` is raised, the two operand registers become one pseudorandom generator twice the operand width. The control register becomes a separate 4-bit pseudorandom generator. Each result is folded into a multi-input signature register. During self-test, every code that is not one-hot is redirected through a parameter table onto a real unit. This means no pattern is spent on an idle datapath, and a unit that needs more patterns can be given more codes.

A session counter stops the session after `PAT_COUNT` patterns and raises `done_o`. The final signature is compared with a parameter value to drive `pass_o`.

Top module: `bist_alu_top`

## Requirements
- R1: In normal mode, operands and code are registered on every edge, and the result appears on `res_o` at the edge after that. The codes are 4'b0001 for a+b, 4'b0010 for a-b, 4'b0100 for a&b and 4'b1000 for a^b, all modulo 2^W.
- R2: In normal mode, a code that is not one-hot gives `res_o` = 0 and `hit_o` = 0. A one-hot code gives `hit_o` = 1.
- R3: On the first edge with `test_mode` high after it was low, the operand pair {a,b} (a in the upper half) loads `SEED_OP`, the code register loads `SEED_CTL`, the signature clears to 0 and the count clears.
- R4: On every later test edge, each generator shifts left and takes into bit 0 the XOR of its state bits selected by its tap mask (`OP_TAPS`, `CTL_TAPS`). With maximal-length masks, the code generator never reaches 0.
- R5: In test mode, a code that is not one-hot uses unit index `REMAP[2*code+1:2*code]`, where 0 is add, 1 is subtract, 2 is AND and 3 is XOR. One-hot codes keep their normal unit, and `hit_o` is always 1.
- R6: For each test pattern, the signature updates as sig = {sig[W-2:0], ^(sig & SIG_TAPS)} ^ result, where result is the value that pattern places on `res_o`.
- R7: After `PAT_COUNT` patterns, `done_o` rises at the edge that compacts the last pattern. From then on the generators, the count and the signature hold.
- R8: `pass_o` is high only while `done_o` is high and the signature equals `GOLDEN`.
- R9: The first edge with `test_mode` low clears `done_o` and `pass_o`. Re-entering test mode repeats the identical session and gives the same signature.
- R10: A synchronous active-low reset clears every register, so `res_o`, `hit_o`, `done_o`, `pass_o` and `sig_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | High selects self-test |
| a_in | input | W | First operand, normal mode |
| b_in | input | W | Second operand, normal mode |
| code_in | input | 4 | One-hot operation code, normal mode |
| res_o | output | W | Registered result |
| hit_o | output | 1 | A functional unit produced `res_o` |
| done_o | output | 1 | Self-test session complete |
| pass_o | output | 1 | Session complete and signature matches |
| sig_o | output | W | Current signature |

## Verification
The assertions take for granted that `test_mode` stays high from its rise until `done_o`. They also take for granted that both seeds are nonzero, because the claims on nonzero codes and on frozen state rely on it. The stimulus changes inputs only at falling edges and holds `test_mode` through each whole session. It sweeps every one of the sixteen codes against a grid of operands in normal mode. It then models both generators, the remap table and the signature pattern by pattern.

// File: rtl/bist_alu_pkg.sv
// Package: shared unit encoding for the self-testing ALU.
// Assumes exactly four functional units addressed by a 2-bit index.
package bist_alu_pkg;
    typedef enum logic [1:0] {
        UNIT_ADD = 2'd0,
        UNIT_SUB = 2'd1,
        UNIT_AND = 2'd2,
        UNIT_XOR = 2'd3
    } unit_e;

    localparam int CODE_W = 4;
    localparam int N_UNITS = 4;
endpackage

// File: rtl/bist_shift_cell.sv
// Module: register that is either loaded in parallel or stepped as a
// Fibonacci shift register; with COMPACT=1 the data input is XORed in,
// turning it into a signature register. Assumes W >= 2.
module bist_shift_cell #(
    parameter int          W       = 8,
    parameter logic [W-1:0] TAPS   = '1,
    parameter bit          COMPACT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         step,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] shifted;
    logic [W-1:0] nxt;

    // feedback: shift left and insert parity of tapped bits
    always_comb begin
        shifted = {q[W-2:0], ^(q & TAPS)};
    end

    // variant pick: compaction folds the data word in
    generate
        if (COMPACT) begin : g_misr
            assign nxt = shifted ^ din;
        end else begin : g_prpg
            assign nxt = shifted;
        end
    endgenerate

    // state register: load has priority over stepping
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (ld)    q <= ld_val;
        else if (step)  q <= nxt;
    end
endmodule

// File: rtl/bist_remap.sv
// Module: control-code decoder. One-hot codes pick their unit; in test
// mode every other code is redirected by the REMAP table so a unit is
// always active. Assumes a 4-bit code.
module bist_remap
    import bist_alu_pkg::*;
#(
    parameter logic [2*(1<<CODE_W)-1:0] REMAP = 32'hE4E4_E4E4
) (
    input  logic [CODE_W-1:0] code,
    input  logic              test_mode,
    output unit_e             unit,
    output logic              hit
);
    logic [1:0] table_idx;

    // table lookup for codes without a one-hot meaning
    always_comb begin
        table_idx = REMAP[{code, 1'b0} +: 2];
    end

    // one-hot decode with test-mode fallback onto the table
    always_comb begin
        unit = UNIT_ADD;
        hit  = 1'b1;
        case (code)
            4'b0001: unit = UNIT_ADD;
            4'b0010: unit = UNIT_SUB;
            4'b0100: unit = UNIT_AND;
            4'b1000: unit = UNIT_XOR;
            default: begin
                unit = unit_e'(table_idx);
                hit  = test_mode;
            end
        endcase
    end
endmodule

// File: rtl/bist_fu_bank.sv
// Module: the four functional units and the result steering. Output is
// zero when no unit is enabled. Assumes modulo-2^W arithmetic.
module bist_fu_bank
    import bist_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  unit_e        unit,
    input  logic         en,
    output logic [W-1:0] y
);
    logic [W-1:0] unit_y [N_UNITS];

    // one datapath per unit index
    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            if (u == 0) begin : g_add
                assign unit_y[u] = a + b;
            end else if (u == 1) begin : g_sub
                assign unit_y[u] = a - b;
            end else if (u == 2) begin : g_and
                assign unit_y[u] = a & b;
            end else begin : g_xor
                assign unit_y[u] = a ^ b;
            end
        end
    endgenerate

    // steer the selected unit, zero when idle
    always_comb begin
        y = en ? unit_y[unit] : '0;
    end
endmodule

// File: rtl/bist_alu_top.sv
// Module: self-testing ALU. Normal mode registers operands and code from
// the ports; test mode turns them into two pseudorandom generators,
// remaps unused codes, compacts results and ends after PAT_COUNT patterns.
// Assumes test_mode is held through a session and seeds are nonzero.
module bist_alu_top
    import bist_alu_pkg::*;
#(
    parameter int                        W         = 8,
    parameter int                        PAT_COUNT = 200,
    parameter logic [2*W-1:0]            SEED_OP   = 16'hACE1,
    parameter logic [CODE_W-1:0]         SEED_CTL  = 4'b1001,
    parameter logic [2*W-1:0]            OP_TAPS   = 16'hB400,
    parameter logic [CODE_W-1:0]         CTL_TAPS  = 4'b1100,
    parameter logic [W-1:0]              SIG_TAPS  = 8'hB8,
    parameter logic [W-1:0]              GOLDEN    = 8'h5A,
    parameter logic [2*(1<<CODE_W)-1:0]  REMAP     = 32'hE4E4_E4E4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      b_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [W-1:0]      res_o,
    output logic              hit_o,
    output logic              done_o,
    output logic              pass_o,
    output logic [W-1:0]      sig_o
);
    localparam int CNT_W = $clog2(PAT_COUNT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_COUNT - 1);

    logic              mode_q;
    logic              done_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              entry;
    logic              adv;
    logic [2*W-1:0]    op_q;
    logic [CODE_W-1:0] ctl_q;
    logic [2*W-1:0]    op_ld_val;
    logic [CODE_W-1:0] ctl_ld_val;
    unit_e             unit;
    logic              hit;
    logic [W-1:0]      y;
    logic [W-1:0]      sig_q;
    logic [W-1:0]      res_q;
    logic              hit_q;

    // session control strobes
    always_comb begin
        entry      = test_mode && !mode_q;
        adv        = test_mode && mode_q && !done_q;
        op_ld_val  = entry ? SEED_OP  : {a_in, b_in};
        ctl_ld_val = entry ? SEED_CTL : code_in;
    end

    // operand pair: one double-width generator in test mode
    bist_shift_cell #(.W(2*W), .TAPS(OP_TAPS), .COMPACT(1'b0)) i_op_gen (
        .clk(clk), .rst_n(rst_n), .ld(!test_mode || entry), .ld_val(op_ld_val),
        .step(adv), .din('0), .q(op_q)
    );

    // control register: its own generator in test mode
    bist_shift_cell #(.W(CODE_W), .TAPS(CTL_TAPS), .COMPACT(1'b0)) i_ctl_gen (
        .clk(clk), .rst_n(rst_n), .ld(!test_mode || entry), .ld_val(ctl_ld_val),
        .step(adv), .din('0), .q(ctl_q)
    );

    bist_remap #(.REMAP(REMAP)) i_remap (
        .code(ctl_q), .test_mode(test_mode), .unit(unit), .hit(hit)
    );

    bist_fu_bank #(.W(W)) i_fu_bank (
        .a(op_q[2*W-1:W]), .b(op_q[W-1:0]), .unit(unit), .en(hit), .y(y)
    );

    // signature register compacting each test result
    bist_shift_cell #(.W(W), .TAPS(SIG_TAPS), .COMPACT(1'b1)) i_misr (
        .clk(clk), .rst_n(rst_n), .ld(entry), .ld_val('0),
        .step(adv), .din(y), .q(sig_q)
    );

    // result and mode pipeline registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            hit_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            res_q  <= y;
            hit_q  <= hit;
            mode_q <= test_mode;
        end
    end

    // pattern counter and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n || !test_mode || entry) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (adv) begin
            cnt_q  <= cnt_q + 1'b1;
            done_q <= (cnt_q == LAST);
        end
    end

    assign res_o  = res_q;
    assign hit_o  = hit_q;
    assign done_o = done_q;
    assign sig_o  = sig_q;
    assign pass_o = done_q && (sig_q == GOLDEN);

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_q |-> (res_q == '0));
    // R5
    test_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> hit_q);
    // R3
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q) |-> (sig_q == '0 && cnt_q == '0 && !done_q));
    // R4
    ctl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && $past(mode_q)) |-> (ctl_q != '0));
    // R7
    frozen_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && $past(done_q)) |-> ($stable(sig_q) && $stable(op_q)));
    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(PAT_COUNT));
    // R8
    pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o);
    // R9
    exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> !done_q);
endmodule

// File: tb/test_bist_alu_top.sv
module test_bist_alu_top;
    localparam int W = 8;
    localparam int NPAT = 200;
    localparam logic [15:0] SEED_OP = 16'hACE1;
    localparam logic [3:0]  SEED_CTL = 4'b1001;
    localparam logic [15:0] OP_TAPS = 16'hB400;
    localparam logic [3:0]  CTL_TAPS = 4'b1100;
    localparam logic [7:0]  SIG_TAPS = 8'hB8;
    localparam logic [7:0]  GOLDEN = 8'h5A;
    localparam logic [31:0] REMAP = 32'hE4E4_E4E4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [3:0] code_in = '0;
    logic [W-1:0] res_o, sig_o;
    logic hit_o, done_o, pass_o;
    int checks = 0;
    int errors = 0;
    logic [7:0] first_sig;

    always #2.5 clk = ~clk;

    bist_alu_top i_bist_alu_top (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .a_in(a_in), .b_in(b_in),
        .code_in(code_in), .res_o(res_o), .hit_o(hit_o), .done_o(done_o),
        .pass_o(pass_o), .sig_o(sig_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] alu(input logic [7:0] a, input logic [7:0] b,
                                       input logic [3:0] c, input bit tm, output bit h);
        int u;
        h = 1'b1;
        case (c)
            4'b0001: u = 0;
            4'b0010: u = 1;
            4'b0100: u = 2;
            4'b1000: u = 3;
            default: begin u = int'(REMAP[2*c +: 2]); h = tm; end
        endcase
        if (!h) return 8'h00;
        case (u)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic run_session(output logic [7:0] sig_out);
        logic [15:0] op = SEED_OP;
        logic [3:0]  ct = SEED_CTL;
        logic [7:0]  sg = '0;
        logic [7:0]  r;
        bit h;
        test_mode = 1'b1;
        @(posedge clk);
        for (int k = 0; k < NPAT; k++) begin
            r  = alu(op[15:8], op[7:0], ct, 1'b1, h);
            sg = {sg[6:0], ^(sg & SIG_TAPS)} ^ r;
            op = {op[14:0], ^(op & OP_TAPS)};
            ct = {ct[2:0], ^(ct & CTL_TAPS)};
            @(posedge clk); @(negedge clk);
            // R4 R5: generated pattern through remap
            chk(res_o == r, "R5", res_o, r);
            chk(hit_o == 1'b1, "R5 hit", hit_o, 1);
            // R6: running signature
            chk(sig_o == sg, "R6", sig_o, sg);
            // R7: done timing
            chk(done_o == (k == NPAT-1), "R7 done", done_o, k == NPAT-1);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sig_o == sg && done_o, "R7 hold", sig_o, sg);
        // R8: pass compare
        chk(pass_o == (sg == GOLDEN), "R8", pass_o, sg == GOLDEN);
        sig_out = sg;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s2, e;
        bit h;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk({res_o, hit_o, done_o, pass_o, sig_o} == '0, "R10", res_o, 0);
        rst_n = 1'b1;
        // R1 R2: sweep every code over an operand grid
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    a_in = 8'(i * 17);
                    b_in = 8'(j * 23 + 5);
                    code_in = 4'(c);
                    e = alu(a_in, b_in, code_in, 1'b0, h);
                    @(posedge clk); @(posedge clk); @(negedge clk);
                    chk(res_o == e, h ? "R1" : "R2", res_o, e);
                    chk(hit_o == h, "R2 hit", hit_o, h);
                end
            end
        end
        // R3: first session from seeds
        run_session(first_sig);
        test_mode = 1'b0;
        @(posedge clk); @(negedge clk);
        // R9: exit clears flags
        chk(!done_o && !pass_o, "R9 exit", done_o, 0);
        run_session(s2);
        chk(s2 == first_sig, "R9 repeat", s2, first_sig);
        test_mode = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk({res_o, hit_o, done_o, pass_o, sig_o} == '0, "R10 again", sig_o, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule